// File: doc/BRIEF.md
# Processor Presence Bitmap Port

This block keeps a byte-readable map of which processors are present on the platform. Every processor owns one bit, and that bit sits at the position given by the processor's interrupt-controller ID. Software reads the map one byte at a time. Each byte carries the presence bits of eight processors. The map can only be read. Bits are set only by a hot-add input and are never cleared, because processor removal is not handled.

When a processor that was not yet present is hot-added, the block sets its presence bit. It also sets the processor-event bit (bit 2) of a general-purpose event status byte. The system-control interrupt output is active while that status bit and the matching enable bit are both 1. Software acknowledges the event by writing 1 to the status bit.

The block also watches for bus writes to the map. Writes never change presence bits. However, when zero has been written to all four bytes of the map's first 32-bit word, the platform leaves legacy mode for the newer selector-based hotplug interface. A mode output reports this switch, which lasts until reset.

Top module: `cpu_presence_port`

## Requirements
- R1: After reset every presence bit reads 0, the event status byte is 0, the interrupt output is low and the mode output is 0 (legacy).
- R2: A hot-add of ID n makes bit n%8 of map byte n/8 read as 1 in the cycle after the hot-add edge. bus_rdata shows the byte addressed by bus_addr without a register stage.
- R3: A bus write to any map byte, with any data, leaves every presence bit unchanged.
- R4: A hot-add of an ID that was not yet present sets gpe_sts bit 2 after that edge. Bits 0, 1 and 3 to 7 of gpe_sts always read 0.
- R5: sci is 1 exactly when gpe_sts bit 2 and gpe_en bit 2 are both 1. The other gpe_en bits have no effect.
- R6: A gpe_clr_valid cycle with gpe_clr_mask bit 2 set clears gpe_sts bit 2. When a new hot-add occurs in the same cycle, the bit stays set.
- R7: A hot-add of an ID that is already present does not set gpe_sts bit 2.
- R8: The mode output rises after the edge on which all four bytes at addresses 0 to 3 hold a zero write mark. A zero write marks its byte, and a nonzero write removes that byte's mark. The bytes may be written in any order.
- R9: Once the mode output is 1, it stays 1 until reset, whatever is written afterwards. Writes to addresses 4 and above never mark a byte.
- R10: No presence bit ever returns from 1 to 0 outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hotadd_valid | input | 1 | Hot-add request for hotadd_id this cycle |
| hotadd_id | input | 8 | Interrupt-controller ID of the added processor |
| bus_addr | input | 5 | Byte address within the map, used for reads and writes |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Map byte at bus_addr |
| gpe_en | input | 8 | Event enable byte; bit 2 gates the interrupt |
| gpe_clr_valid | input | 1 | Write-one-to-clear strobe for the status byte |
| gpe_clr_mask | input | 8 | Status bits to clear |
| gpe_sts | output | 8 | Event status byte; bit 2 is the processor event |
| sci | output | 1 | System-control interrupt |
| new_mode | output | 1 | 1 once the switch to the selector interface has occurred |

## Verification
The hardest situation to reach from the ports is a partial zero pattern on the first word. For example, three bytes are marked, and then a nonzero write to one of them removes its mark, so the next zero write to that byte becomes the one that triggers the switch. Random bus traffic alone rarely produces such a sequence before a switch has already happened. A directed sequence therefore builds it explicitly and checks that the mode output stays low until the final re-marking write. Random traffic that favours zero data and the low four addresses then runs after a fresh reset, so that switches occur at varied points. Hot-adds that coincide with acknowledgements, and repeated hot-adds of IDs already present, are also driven directly.

// File: rtl/cpu_presence_pkg.sv
package cpu_presence_pkg;
    localparam int GPE_W       = 8;
    localparam int CPU_EVT_BIT = 2;
    localparam int WORD0_BYTES = 4;

    typedef struct packed {
        logic [WORD0_BYTES-1:0] zero_seen;
        logic                   switched;
    } mode_state_t;

    typedef struct packed {
        logic [GPE_W-1:0] sts;
    } gpe_state_t;
endpackage

// File: rtl/cpu_present_map.sv
module cpu_present_map #(
    parameter int NUM_CPUS = 256,
    localparam int ID_W      = $clog2(NUM_CPUS),
    localparam int MAP_BYTES = NUM_CPUS / 8,
    localparam int ADDR_W    = $clog2(MAP_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                add_valid,
    input  logic [ID_W-1:0]     add_id,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [7:0]          rd_byte,
    output logic                new_add,
    output logic [NUM_CPUS-1:0] present
);
    typedef struct packed {
        logic [NUM_CPUS-1:0] bits;
    } map_state_t;

    map_state_t state_d, state_q;
    logic [7:0] byte_view [MAP_BYTES];

    always_comb begin
        state_d = state_q;
        new_add = add_valid && !state_q.bits[add_id];
        if (add_valid) begin
            state_d.bits[add_id] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar g = 0; g < MAP_BYTES; g++) begin : g_bytes
        assign byte_view[g] = state_q.bits[g*8 +: 8];
    end

    assign rd_byte = byte_view[rd_addr];
    assign present = state_q.bits;
endmodule

// File: rtl/cpu_mode_switch.sv
module cpu_mode_switch
    import cpu_presence_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              new_mode
);
    mode_state_t state_d, state_q;
    logic in_word0;

    assign in_word0 = (wr_addr[ADDR_W-1:2] == '0);

    always_comb begin
        state_d = state_q;
        if (!state_q.switched && wr_en && in_word0) begin
            state_d.zero_seen[wr_addr[1:0]] = (wr_data == 8'h00);
            if (&state_d.zero_seen) begin
                state_d.switched = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign new_mode = state_q.switched;
endmodule

// File: rtl/cpu_gpe_event.sv
module cpu_gpe_event
    import cpu_presence_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raise,
    input  logic             clr_valid,
    input  logic [GPE_W-1:0] clr_mask,
    input  logic [GPE_W-1:0] en,
    output logic [GPE_W-1:0] sts,
    output logic             sci
);
    localparam logic [GPE_W-1:0] EVT_MASK = GPE_W'(1) << CPU_EVT_BIT;

    gpe_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr_valid) begin
            state_d.sts = state_q.sts & ~clr_mask;
        end
        if (raise) begin
            state_d.sts[CPU_EVT_BIT] = 1'b1;
        end
        state_d.sts = state_d.sts & EVT_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sts = state_q.sts;
    assign sci = |(state_q.sts & en);
endmodule

// File: rtl/cpu_presence_port.sv
module cpu_presence_port
    import cpu_presence_pkg::*;
#(
    parameter int NUM_CPUS = 256,
    localparam int ID_W      = $clog2(NUM_CPUS),
    localparam int MAP_BYTES = NUM_CPUS / 8,
    localparam int ADDR_W    = $clog2(MAP_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hotadd_valid,
    input  logic [ID_W-1:0]   hotadd_id,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [GPE_W-1:0]  gpe_en,
    input  logic              gpe_clr_valid,
    input  logic [GPE_W-1:0]  gpe_clr_mask,
    output logic [GPE_W-1:0]  gpe_sts,
    output logic              sci,
    output logic              new_mode
);
    logic                new_add;
    logic [NUM_CPUS-1:0] present_bits;

    cpu_present_map #(.NUM_CPUS(NUM_CPUS)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_valid(hotadd_valid),
        .add_id   (hotadd_id),
        .rd_addr  (bus_addr),
        .rd_byte  (bus_rdata),
        .new_add  (new_add),
        .present  (present_bits)
    );

    cpu_mode_switch #(.ADDR_W(ADDR_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .new_mode(new_mode)
    );

    cpu_gpe_event u_gpe (
        .clk      (clk),
        .rst_n    (rst_n),
        .raise    (new_add),
        .clr_valid(gpe_clr_valid),
        .clr_mask (gpe_clr_mask),
        .en       (gpe_en),
        .sts      (gpe_sts),
        .sci      (sci)
    );
endmodule

// File: rtl/cpu_presence_port_chk.sv
module cpu_presence_port_chk #(
    parameter int NUM_CPUS = 256,
    localparam int ID_W = $clog2(NUM_CPUS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hotadd_valid,
    input logic [ID_W-1:0]     hotadd_id,
    input logic                bus_wr,
    input logic [7:0]          gpe_en,
    input logic                gpe_clr_valid,
    input logic [7:0]          gpe_clr_mask,
    input logic [7:0]          gpe_sts,
    input logic                sci,
    input logic                new_mode,
    input logic [NUM_CPUS-1:0] present_bits
);
    logic fresh_add;
    assign fresh_add = hotadd_valid && !present_bits[hotadd_id];

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (present_bits == '0 && gpe_sts == 8'h00 && !new_mode));

    assert_write_keeps_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hotadd_valid) |=> $stable(present_bits));

    assert_fresh_add_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fresh_add |=> gpe_sts[2]);

    assert_unused_sts_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gpe_sts[7:3] == 5'd0 && gpe_sts[1:0] == 2'd0));

    assert_sci_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sci |-> (gpe_sts[2] && gpe_en[2]));

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gpe_clr_valid && gpe_clr_mask[2] && !fresh_add) |=> !gpe_sts[2]);

    assert_no_repeat_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!gpe_sts[2] && !fresh_add) |=> !gpe_sts[2]);

    assert_mode_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        new_mode |=> new_mode);

    assert_bits_never_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((present_bits & $past(present_bits)) == $past(present_bits)));
endmodule

bind cpu_presence_port cpu_presence_port_chk #(.NUM_CPUS(NUM_CPUS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hotadd_valid (hotadd_valid),
    .hotadd_id    (hotadd_id),
    .bus_wr       (bus_wr),
    .gpe_en       (gpe_en),
    .gpe_clr_valid(gpe_clr_valid),
    .gpe_clr_mask (gpe_clr_mask),
    .gpe_sts      (gpe_sts),
    .sci          (sci),
    .new_mode     (new_mode),
    .present_bits (present_bits)
);

// File: tb/cpu_presence_port_tb.sv
`timescale 1ns/1ps
module cpu_presence_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hotadd_valid = 1'b0;
    logic [7:0] hotadd_id = '0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] gpe_en = '0;
    logic       gpe_clr_valid = 1'b0;
    logic [7:0] gpe_clr_mask = '0;
    logic [7:0] gpe_sts;
    logic       sci;
    logic       new_mode;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [255:0] m_map;
    logic         m_sts;
    logic         m_mode;
    logic [3:0]   m_zero;

    always #10 clk = ~clk;

    cpu_presence_port u_dut (
        .clk(clk), .rst_n(rst_n), .hotadd_valid(hotadd_valid), .hotadd_id(hotadd_id),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gpe_en(gpe_en), .gpe_clr_valid(gpe_clr_valid), .gpe_clr_mask(gpe_clr_mask),
        .gpe_sts(gpe_sts), .sci(sci), .new_mode(new_mode)
    );

    function automatic logic [7:0] exp_byte(input logic [4:0] a);
        return m_map[a*8 +: 8];
    endfunction

    function automatic logic [7:0] exp_sts_byte();
        return {5'd0, m_sts, 2'd0};
    endfunction

    function automatic logic exp_sci(input logic [7:0] en);
        return m_sts & en[2];
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_map = '0; m_sts = 1'b0; m_mode = 1'b0; m_zero = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        hotadd_valid = 0; bus_wr = 0; gpe_clr_valid = 0; gpe_clr_mask = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic step(input logic hv, input logic [7:0] id, input logic [4:0] addr,
                        input logic wr, input logic [7:0] wd, input logic cv,
                        input logic [7:0] cm, input logic [7:0] en);
        logic fresh;
        hotadd_valid = hv; hotadd_id = id; bus_addr = addr; bus_wr = wr; bus_wdata = wd;
        gpe_clr_valid = cv; gpe_clr_mask = cm; gpe_en = en;
        fresh = hv && !m_map[id];
        if (cv && cm[2]) m_sts = 1'b0;
        if (fresh) m_sts = 1'b1;
        if (hv) m_map[id] = 1'b1;
        if (!m_mode && wr && addr < 5'd4) begin
            m_zero[addr[1:0]] = (wd == 8'h00);
            if (&m_zero) m_mode = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        hotadd_valid = 1'b0; bus_wr = 1'b0; gpe_clr_valid = 1'b0;
        chk("R2 rdata", bus_rdata, exp_byte(addr));
        chk("R4 gpe_sts", gpe_sts, exp_sts_byte());
        chk("R5 sci", {7'd0, sci}, {7'd0, exp_sci(en)});
        chk("R8 new_mode", {7'd0, new_mode}, {7'd0, m_mode});
    endtask

    task automatic idle(input logic [4:0] addr, input logic [7:0] en);
        step(1'b0, 8'd0, addr, 1'b0, 8'd0, 1'b0, 8'd0, en);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        do_reset();

        // R1: reset state
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 gpe_sts", gpe_sts, 8'h00);
        chk("R1 sci", {7'd0, sci}, 8'h00);
        chk("R1 new_mode", {7'd0, new_mode}, 8'h00);

        // R2/R4: hot-adds at the edges of the ID space
        step(1'b1, 8'd0, 5'd0, 1'b0, 8'd0, 1'b0, 8'd0, 8'h04);
        chk("R2 id0", bus_rdata, 8'h01);
        step(1'b1, 8'd255, 5'd31, 1'b0, 8'd0, 1'b0, 8'd0, 8'h04);
        chk("R2 id255", bus_rdata, 8'h80);
        step(1'b1, 8'd13, 5'd1, 1'b0, 8'd0, 1'b0, 8'd0, 8'h04);
        chk("R2 id13", bus_rdata, 8'h20);

        // R3: writes to map bytes have no effect on presence bits
        step(1'b0, 8'd0, 5'd1, 1'b1, 8'hFF, 1'b0, 8'd0, 8'h04);
        chk("R3 write ff", bus_rdata, 8'h20);
        step(1'b0, 8'd0, 5'd31, 1'b1, 8'h00, 1'b0, 8'd0, 8'h04);
        chk("R3 write 00", bus_rdata, 8'h80);

        // R5: only enable bit 2 gates the interrupt
        idle(5'd0, 8'hFB);
        chk("R5 en2 off", {7'd0, sci}, 8'h00);

        // R6: acknowledge clears; simultaneous new add wins
        step(1'b0, 8'd0, 5'd0, 1'b0, 8'd0, 1'b1, 8'h04, 8'h04);
        chk("R6 cleared", gpe_sts, 8'h00);
        step(1'b1, 8'd40, 5'd5, 1'b0, 8'd0, 1'b1, 8'h04, 8'h04);
        chk("R6 set wins", gpe_sts, 8'h04);
        step(1'b0, 8'd0, 5'd5, 1'b0, 8'd0, 1'b1, 8'hFB, 8'h04);
        chk("R6 other mask bits", gpe_sts, 8'h04);
        step(1'b0, 8'd0, 5'd5, 1'b0, 8'd0, 1'b1, 8'h04, 8'h04);

        // R7: repeated hot-add of a present ID raises nothing
        step(1'b1, 8'd40, 5'd5, 1'b0, 8'd0, 1'b0, 8'd0, 8'h04);
        chk("R7 repeat add", gpe_sts, 8'h00);
        chk("R7 repeat sci", {7'd0, sci}, 8'h00);

        // R8: partial zero pattern with a withdrawn mark
        step(1'b0, 8'd0, 5'd0, 1'b1, 8'h00, 1'b0, 8'd0, 8'h04);
        step(1'b0, 8'd0, 5'd2, 1'b1, 8'h00, 1'b0, 8'd0, 8'h04);
        step(1'b0, 8'd0, 5'd4, 1'b1, 8'h00, 1'b0, 8'd0, 8'h04);
        step(1'b0, 8'd0, 5'd1, 1'b1, 8'h00, 1'b0, 8'd0, 8'h04);
        step(1'b0, 8'd0, 5'd1, 1'b1, 8'h5A, 1'b0, 8'd0, 8'h04);
        step(1'b0, 8'd0, 5'd3, 1'b1, 8'h00, 1'b0, 8'd0, 8'h04);
        chk("R8 withdrawn mark", {7'd0, new_mode}, 8'h00);
        step(1'b0, 8'd0, 5'd1, 1'b1, 8'h00, 1'b0, 8'd0, 8'h04);
        chk("R8 switched", {7'd0, new_mode}, 8'h01);

        // R9: sticky after nonzero writes
        step(1'b0, 8'd0, 5'd0, 1'b1, 8'hFF, 1'b0, 8'd0, 8'h04);
        step(1'b0, 8'd0, 5'd3, 1'b1, 8'h11, 1'b0, 8'd0, 8'h04);
        chk("R9 sticky", {7'd0, new_mode}, 8'h01);

        // R10: bits survive, byte 0 still holds id0
        idle(5'd0, 8'h04);
        chk("R10 kept", bus_rdata, 8'h01);

        // Random phase after a fresh reset
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            logic       hv = ($urandom_range(0, 3) == 0);
            logic [7:0] id = (i < 2000) ? 8'($urandom_range(0, 63)) : 8'($urandom);
            logic       wr = ($urandom_range(0, 2) == 0);
            logic [4:0] ad = ($urandom_range(0, 1) == 0) ? 5'($urandom_range(0, 3)) : 5'($urandom);
            logic [7:0] wd = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'($urandom);
            logic       cv = ($urandom_range(0, 4) == 0);
            logic [7:0] cm = 8'($urandom);
            logic [7:0] en = 8'($urandom);
            if (i % 1000 == 999) begin
                do_reset();
                chk("R1 rerun", {7'd0, new_mode}, 8'h00);
            end
            step(hv, id, ad, wr, wd, cv, cm, en);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule